// File: doc/BRIEF.md
# Address Translation Lookaside Buffer

This block is a small fully associative translation cache for 4 KiB pages in a 32-bit address space. Each lookup presents a full virtual address, an 8-bit address-space identifier and an access type. In the same cycle the block returns whether a translation was found, the physical address, the page's cacheable attribute and a permission-fault flag. The physical address is the stored physical page number placed above the untouched 12-bit page offset.

Translations are loaded through a write port. A load picks its slot in this order: the entry already holding the same page and identifier, then the lowest-numbered empty entry, then a round-robin victim. Single entries can be removed by page and identifier, and a flush clears every entry at once. On a miss the block only reports it: page-table walking and exception handling are out of scope.

Top module: `addr_xlate_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses and `lk_fault` stays 0.
- R2: A lookup hits when a valid entry's page number equals `lk_vaddr[31:12]` and its identifier equals `lk_asid`. `lk_paddr` is then the entry's physical page number in bits 31:12 with `lk_vaddr[11:0]` unchanged in bits 11:0.
- R3: The same virtual page loaded under two identifiers gives two independent translations. A lookup with any other identifier misses.
- R4: On a miss `lk_hit` is 0, `lk_fault` is 0, `lk_cacheable` is 0 and `lk_paddr` is `{20'h0, lk_vaddr[11:0]}`.
- R5: On a hit, `lk_fault` is 1 only when the entry's permission bit for the access is clear. The read permission applies when `lk_is_write` = 0, and the write permission applies when `lk_is_write` = 1.
- R6: On a hit, `lk_cacheable` equals the cacheable bit loaded with that entry.
- R7: A load whose key is not present fills the lowest-numbered empty entry and leaves the victim pointer unchanged. When no entry is empty, it replaces the entry at the victim pointer. The pointer starts at entry 0 after reset and steps by one, wrapping, after each such replacement.
- R8: A load whose page and identifier are already present overwrites that entry. No other translation is lost.
- R9: Asserting `inv_en` removes the entry that matches `inv_vpn` and `inv_asid`. All other entries keep their translations.
- R10: Asserting `inv_all` empties every entry at the clock edge.
- R11: A load becomes visible from the cycle after its clock edge. A lookup in the load cycle itself sees the contents from before the load.
- R12: When `inv_all` and `wr_en` are both asserted in one cycle, the flush wins and the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Identifier of the requesting address space |
| lk_is_write | input | 1 | Access type: 0 read, 1 write |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Translated physical address |
| lk_fault | output | 1 | Hit with the needed permission missing |
| lk_cacheable | output | 1 | Cacheable attribute of the hit entry |
| wr_en | input | 1 | Load a translation |
| wr_vpn | input | 20 | Virtual page number to load |
| wr_asid | input | 8 | Identifier to load |
| wr_ppn | input | 20 | Physical page number to load |
| wr_rd_ok | input | 1 | Read permission to load |
| wr_wr_ok | input | 1 | Write permission to load |
| wr_cache | input | 1 | Cacheable attribute to load |
| inv_en | input | 1 | Remove one translation |
| inv_vpn | input | 20 | Page number to remove |
| inv_asid | input | 8 | Identifier to remove |
| inv_all | input | 1 | Remove every translation |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a combinational lookup and a load of the same key. The bench drives both between two edges and expects a miss at once, then a hit one cycle later. The second pair is a flush and a load. The bench raises both together and then expects the loaded key and an older key to miss.

// File: rtl/xlate_pkg.sv
// Package: shared widths and the per-entry attribute type of the
// translation cache. Assumes 32-bit addresses and 4 KiB pages.
package xlate_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFS_W    = 12;
    localparam int PAGE_W   = ADDR_W - OFS_W;
    localparam int ID_W     = 8;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        logic cache;
    } page_attr_t;
endpackage

// File: rtl/xlate_entry.sv
// One translation slot: holds the valid flag, key, physical page and
// attributes, and compares its key against the lookup, load and removal
// keys. Assumes at most one of flush / load acts per edge, with flush first.
module xlate_entry
    import xlate_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int AS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [AS_W-1:0]  wr_asid,
    input  logic [PPN_W-1:0] wr_ppn,
    input  page_attr_t       wr_attr,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [AS_W-1:0]  inv_asid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [AS_W-1:0]  lk_asid,
    output logic             valid,
    output logic             lk_match,
    output logic             wr_match,
    output logic [PPN_W-1:0] ppn,
    output page_attr_t       attr
);
    logic [VPN_W-1:0] vpn_q;
    logic [AS_W-1:0]  asid_q;
    logic             inv_match;

    // Key comparisons for the three ports that address entries by key.
    always_comb begin
        lk_match  = valid && (vpn_q == lk_vpn)  && (asid_q == lk_asid);
        wr_match  = valid && (vpn_q == wr_vpn)  && (asid_q == wr_asid);
        inv_match = valid && (vpn_q == inv_vpn) && (asid_q == inv_asid);
    end

    // Slot state: flush beats load, load beats single removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            vpn_q  <= '0;
            asid_q <= '0;
            ppn    <= '0;
            attr   <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (load) begin
            valid  <= 1'b1;
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            ppn    <= wr_ppn;
            attr   <= wr_attr;
        end else if (inv_en && inv_match) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/xlate_victim.sv
// Slot chooser for loads: an existing key match first, then the lowest
// empty slot, then the round-robin pointer. Assumes key_hit is one-hot or 0.
module xlate_victim #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] valid_vec,
    input  logic [N-1:0] key_hit,
    output logic [N-1:0] sel
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] rr_ptr;
    logic [N-1:0]  free_sel;
    logic          any_free;
    logic          full_evict;

    // Lowest-index empty slot as a one-hot vector.
    always_comb begin
        free_sel = '0;
        any_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid_vec[i] && !any_free) begin
                free_sel[i] = 1'b1;
                any_free    = 1'b1;
            end
        end
    end

    // Final choice by priority: key match, empty slot, round-robin victim.
    always_comb begin
        full_evict = 1'b0;
        if (|key_hit)      sel = key_hit;
        else if (any_free) sel = free_sel;
        else begin
            sel        = '0;
            sel[rr_ptr] = 1'b1;
            full_evict = 1'b1;
        end
    end

    // Victim pointer advances only when a replacement consumed it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rr_ptr <= '0;
        else if (fire && full_evict) rr_ptr <= (rr_ptr == IW'(N-1)) ? '0 : rr_ptr + 1'b1;
    end

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $onehot(sel));

    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !(&valid_vec)) |=> $stable(rr_ptr));
endmodule

// File: rtl/addr_xlate_cache.sv
// Top of the translation cache: a row of slots, the load-slot chooser and
// the combinational lookup with permission check. Assumes the key stored
// in a slot is unique, which the overwrite-on-match rule keeps true.
module addr_xlate_cache
    import xlate_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PG_OFS  = 12,
    parameter int AS_W    = 8,
    localparam int VPN_W  = VA_W - PG_OFS,
    localparam int PPN_W  = PA_W - PG_OFS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [AS_W-1:0]  lk_asid,
    input  logic             lk_is_write,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             lk_fault,
    output logic             lk_cacheable,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [AS_W-1:0]  wr_asid,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_rd_ok,
    input  logic             wr_wr_ok,
    input  logic             wr_cache,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [AS_W-1:0]  inv_asid,
    input  logic             inv_all
);
    logic [NUM_ENT-1:0] valid_vec, lk_vec, wr_vec, sel;
    logic [PPN_W-1:0]   ent_ppn  [NUM_ENT];
    page_attr_t         ent_attr [NUM_ENT];
    page_attr_t         wr_attr, hit_attr;
    logic [PPN_W-1:0]   hit_ppn;
    logic               wr_fire;

    // Load is accepted only when no flush is requested in the same cycle.
    always_comb begin
        wr_fire = wr_en && !inv_all;
        wr_attr = '{rd_ok: wr_rd_ok, wr_ok: wr_wr_ok, cache: wr_cache};
    end

    xlate_victim #(.N(NUM_ENT)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (wr_fire),
        .valid_vec (valid_vec),
        .key_hit   (wr_vec),
        .sel       (sel)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        xlate_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .AS_W(AS_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (inv_all),
            .load     (wr_fire && sel[g]),
            .wr_vpn   (wr_vpn),
            .wr_asid  (wr_asid),
            .wr_ppn   (wr_ppn),
            .wr_attr  (wr_attr),
            .inv_en   (inv_en),
            .inv_vpn  (inv_vpn),
            .inv_asid (inv_asid),
            .lk_vpn   (lk_vaddr[VA_W-1:PG_OFS]),
            .lk_asid  (lk_asid),
            .valid    (valid_vec[g]),
            .lk_match (lk_vec[g]),
            .wr_match (wr_vec[g]),
            .ppn      (ent_ppn[g]),
            .attr     (ent_attr[g])
        );
    end

    // OR-select of the single matching slot's page and attributes.
    always_comb begin
        hit_ppn  = '0;
        hit_attr = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (lk_vec[i]) begin
                hit_ppn  = hit_ppn | ent_ppn[i];
                hit_attr = hit_attr | ent_attr[i];
            end
        end
    end

    // Lookup outputs: address splice, attribute and permission check.
    always_comb begin
        lk_hit       = |lk_vec;
        lk_paddr     = {hit_ppn, lk_vaddr[PG_OFS-1:0]};
        lk_cacheable = hit_attr.cache;
        lk_fault     = lk_hit && (lk_is_write ? !hit_attr.wr_ok : !hit_attr.rd_ok);
    end

    // R8
    uniq_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    // R4
    miss_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (!lk_fault && !lk_cacheable));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R7
    fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !inv_en && !(|wr_vec) && !(&valid_vec))
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));
endmodule

// File: tb/addr_xlate_cache_test.sv
// Directed bench for the translation cache: one task per scenario.
module addr_xlate_cache_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        lk_is_write;
    logic        lk_hit, lk_fault, lk_cacheable;
    logic [31:0] lk_paddr;
    logic        wr_en, wr_rd_ok, wr_wr_ok, wr_cache;
    logic [19:0] wr_vpn, wr_ppn, inv_vpn;
    logic [7:0]  wr_asid, inv_asid;
    logic        inv_en, inv_all;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_xlate_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_is_write(lk_is_write),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_fault(lk_fault),
        .lk_cacheable(lk_cacheable),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn),
        .wr_rd_ok(wr_rd_ok), .wr_wr_ok(wr_wr_ok), .wr_cache(wr_cache),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
        .inv_all(inv_all)
    );

    task automatic look(input logic [31:0] va, input logic [7:0] id, input logic w);
        lk_vaddr = va; lk_asid = id; lk_is_write = w;
        #1;
    endtask

    task automatic expect_lk(input string req, input logic [31:0] va, input logic [7:0] id,
                             input logic w, input logic e_hit, input logic [19:0] e_ppn,
                             input logic e_flt, input logic e_c);
        logic [31:0] e_pa;
        look(va, id, w);
        e_pa = {e_hit ? e_ppn : 20'h0, va[11:0]};
        n_chk++;
        if (lk_hit !== e_hit || lk_paddr !== e_pa || lk_fault !== e_flt || lk_cacheable !== e_c) begin
            n_fail++;
            $display("FAIL %s va=%h id=%h: got hit=%b pa=%h flt=%b c=%b, expected hit=%b pa=%h flt=%b c=%b",
                     req, va, id, lk_hit, lk_paddr, lk_fault, lk_cacheable, e_hit, e_pa, e_flt, e_c);
        end
    endtask

    // Drive a load for one clock edge, from one falling edge to the next.
    task automatic install(input logic [19:0] v, input logic [7:0] id, input logic [19:0] p,
                           input logic r, input logic w, input logic c);
        @(negedge clk);
        wr_en = 1; wr_vpn = v; wr_asid = id; wr_ppn = p;
        wr_rd_ok = r; wr_wr_ok = w; wr_cache = c;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic remove(input logic [19:0] v, input logic [7:0] id);
        @(negedge clk);
        inv_en = 1; inv_vpn = v; inv_asid = id;
        @(negedge clk);
        inv_en = 0;
    endtask

    task automatic flush_all();
        @(negedge clk); inv_all = 1;
        @(negedge clk); inv_all = 0;
    endtask

    task automatic t_reset();
        expect_lk("R1", 32'h0000_0000, 8'h00, 0, 0, 0, 0, 0);
        expect_lk("R1", 32'hFFFF_F123, 8'hFF, 1, 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        install(20'h00AB1, 8'h05, 20'h12345, 1, 1, 1);
        expect_lk("R2", 32'h00AB_1134, 8'h05, 0, 1, 20'h12345, 0, 1);
        expect_lk("R6", 32'h00AB_1FFF, 8'h05, 1, 1, 20'h12345, 0, 1);
        expect_lk("R4", 32'h00AB_2FFF, 8'h05, 0, 0, 0, 0, 0);
    endtask

    task automatic t_asid();
        install(20'h00AB1, 8'h09, 20'h0BEEF, 1, 1, 0);
        expect_lk("R3", 32'h00AB_1010, 8'h05, 0, 1, 20'h12345, 0, 1);
        expect_lk("R3", 32'h00AB_1010, 8'h09, 0, 1, 20'h0BEEF, 0, 0);
        expect_lk("R3", 32'h00AB_1010, 8'h07, 0, 0, 0, 0, 0);
    endtask

    task automatic t_perm();
        install(20'h40000, 8'h01, 20'h00777, 0, 1, 0);
        install(20'h40001, 8'h01, 20'h00778, 1, 0, 1);
        expect_lk("R5", 32'h4000_0008, 8'h01, 0, 1, 20'h00777, 1, 0);
        expect_lk("R5", 32'h4000_0008, 8'h01, 1, 1, 20'h00777, 0, 0);
        expect_lk("R5", 32'h4000_1008, 8'h01, 1, 1, 20'h00778, 1, 1);
        expect_lk("R5", 32'h4000_1008, 8'h01, 0, 1, 20'h00778, 0, 1);
    endtask

    task automatic t_overwrite();
        install(20'h00AB1, 8'h05, 20'h55555, 1, 1, 1);
        expect_lk("R8", 32'h00AB_1000, 8'h05, 0, 1, 20'h55555, 0, 1);
        expect_lk("R8", 32'h00AB_1000, 8'h09, 0, 1, 20'h0BEEF, 0, 0);
        expect_lk("R8", 32'h4000_0000, 8'h01, 1, 1, 20'h00777, 0, 0);
    endtask

    task automatic t_flush();
        flush_all();
        expect_lk("R10", 32'h00AB_1000, 8'h05, 0, 0, 0, 0, 0);
        expect_lk("R10", 32'h4000_1000, 8'h01, 0, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1; wr_vpn = 20'h11111; wr_asid = 8'h02; wr_ppn = 20'h22222;
        wr_rd_ok = 1; wr_wr_ok = 1; wr_cache = 0;
        expect_lk("R11", 32'h1111_1ABC, 8'h02, 0, 0, 0, 0, 0);
        @(negedge clk);
        wr_en = 0;
        expect_lk("R11", 32'h1111_1ABC, 8'h02, 0, 1, 20'h22222, 0, 0);
    endtask

    task automatic t_flush_vs_load();
        @(negedge clk);
        inv_all = 1; wr_en = 1; wr_vpn = 20'h33333; wr_asid = 8'h02; wr_ppn = 20'h44444;
        wr_rd_ok = 1; wr_wr_ok = 1; wr_cache = 1;
        @(negedge clk);
        inv_all = 0; wr_en = 0;
        expect_lk("R12", 32'h3333_3000, 8'h02, 0, 0, 0, 0, 0);
        expect_lk("R12", 32'h1111_1000, 8'h02, 0, 0, 0, 0, 0);
    endtask

    task automatic t_replace();
        for (int i = 0; i < 8; i++) install(20'h50000 + 20'(i), 8'h03, 20'h60000 + 20'(i), 1, 1, 0);
        for (int i = 0; i < 8; i++)
            expect_lk("R7", {20'h50000 + 20'(i), 12'h004}, 8'h03, 0, 1, 20'h60000 + 20'(i), 0, 0);
        install(20'h50008, 8'h03, 20'h60008, 1, 1, 0);
        expect_lk("R7", 32'h5000_0004, 8'h03, 0, 0, 0, 0, 0);
        expect_lk("R7", 32'h5000_1004, 8'h03, 0, 1, 20'h60001, 0, 0);
        expect_lk("R7", 32'h5000_8004, 8'h03, 0, 1, 20'h60008, 0, 0);
        remove(20'h50005, 8'h03);
        expect_lk("R9", 32'h5000_5004, 8'h03, 0, 0, 0, 0, 0);
        expect_lk("R9", 32'h5000_4004, 8'h03, 0, 1, 20'h60004, 0, 0);
        expect_lk("R9", 32'h5000_6004, 8'h03, 0, 1, 20'h60006, 0, 0);
        install(20'h50009, 8'h03, 20'h60009, 1, 1, 0);
        expect_lk("R7", 32'h5000_9004, 8'h03, 0, 1, 20'h60009, 0, 0);
        expect_lk("R7", 32'h5000_1004, 8'h03, 0, 1, 20'h60001, 0, 0);
        install(20'h5000A, 8'h03, 20'h6000A, 1, 1, 0);
        expect_lk("R7", 32'h5000_1004, 8'h03, 0, 0, 0, 0, 0);
        expect_lk("R7", 32'h5000_2004, 8'h03, 0, 1, 20'h60002, 0, 0);
        expect_lk("R7", 32'h5000_A004, 8'h03, 0, 1, 20'h6000A, 0, 0);
        expect_lk("R7", 32'h5000_9004, 8'h03, 0, 1, 20'h60009, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; lk_vaddr = 0; lk_asid = 0; lk_is_write = 0;
        wr_en = 0; wr_vpn = 0; wr_asid = 0; wr_ppn = 0;
        wr_rd_ok = 0; wr_wr_ok = 0; wr_cache = 0;
        inv_en = 0; inv_vpn = 0; inv_asid = 0; inv_all = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_asid();
        t_perm();
        t_overwrite();
        t_flush();
        t_same_cycle();
        t_flush_vs_load();
        t_replace();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end
endmodule